// File: doc/BRIEF.md
# Secure Boot Memory Sanitizing Sequencer

This block runs once when reset is released. It decides whether the device is locked and was started in the bootstrap mode. If both hold, it wipes the protected memories before the boot loader may go on. The wipe has a fixed order:

1. Announce the wipe by sending one blank byte to the serial transmitter.
2. Lift the nonvolatile write protection.
3. Bulk-erase the EEPROM, then read every location back to confirm that it is blank.
4. Fill the whole RAM with the blank pattern.
5. Erase the configuration word.

A verify miss throws the sequence back to step 1 and bumps a retry count. On a device that is not locked, or not in bootstrap mode, the block reports done at once and issues no wipe request.

The sequencer is a single state machine with these states:

- `ST_IDLE` decides the path.
- `ST_SEND` waits on the serial byte.
- `ST_UNPROT` waits on the protect clear.
- `ST_ERASE` waits on the bulk erase.
- `ST_VERIFY` reads the EEPROM back.
- `ST_FILL` writes the RAM.
- `ST_CFGCLR` waits on the configuration erase.
- `ST_DONE` gives a one-cycle done pulse.
- `ST_HALT` holds until the next reset.

The transitions are:

- `ST_IDLE` goes to `ST_SEND` when the wipe is armed, and to `ST_DONE` otherwise.
- `ST_SEND` goes to `ST_UNPROT` when `tx_ready` is high.
- `ST_UNPROT` goes to `ST_ERASE` when the EEPROM enable bit is set, and to `ST_FILL` when it is clear.
- `ST_ERASE` goes to `ST_VERIFY` on the erase acknowledge.
- `ST_VERIFY` goes to `ST_SEND` on a non-blank byte, and to `ST_FILL` after a blank last byte.
- `ST_FILL` goes to `ST_CFGCLR` after the last RAM acknowledge.
- `ST_CFGCLR` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_HALT`.

Every request is held until its acknowledge is seen on a rising edge. One location is processed per acknowledged handshake.

Top module: `secure_wipe_seq`

## Requirements
- R1: The wipe runs only when `sec_fitted` is 1, configuration bit 3 (the security-disable bit, 1 = disabled) is 0, and `mode_pins` equals 2'b00 (bootstrap). In every other case `boot_done` pulses on the first clock edge after reset release, and no wipe request is ever raised.
- R2: `force_single_chip` becomes 1 after reset release whenever `sec_fitted` is 1 and configuration bit 3 is 0, whatever the mode pins are. It stays 1 until reset.
- R3: The first wipe step raises `tx_valid` with `tx_data` = 0xFF and holds both until `tx_ready` is seen.
- R4: A protect-clear handshake (`prot_clr` and `prot_ack`) completes in each pass before `ee_erase` is raised.
- R5: When configuration bit 0 (EEPROM enable) is 1, one bulk-erase handshake and a full read-back follow the protect clear. When it is 0, both are skipped and the RAM fill starts directly.
- R6: The read-back visits EEPROM addresses 0 to EE_DEPTH-1 in ascending order. Any byte other than 0xFF restarts the sequence at the serial step and increments `retry_cnt`, which saturates at its maximum.
- R7: The RAM fill writes 0xFF to every address from 0 to RAM_DEPTH-1 in ascending order, one per `ram_ack`. The address and data are held while the acknowledge is low.
- R8: After the RAM fill, one configuration-erase handshake occurs. Then `boot_done` is high for exactly one cycle and stays low until reset.
- R9: A synchronous `rst` returns the block to idle with all requests low, `retry_cnt` at 0 and `force_single_chip` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_fitted | input | 1 | Security option present |
| mode_pins | input | 2 | Boot mode pins, 2'b00 = bootstrap |
| cfg_word | input | 8 | Configuration word; bit 3 = security disable, bit 0 = EEPROM enable |
| tx_valid | output | 1 | Serial byte request |
| tx_data | output | 8 | Serial byte (0xFF while requesting) |
| tx_ready | input | 1 | Serial byte accepted |
| prot_clr | output | 1 | Protect-register clear request |
| prot_ack | input | 1 | Protect clear done |
| ee_erase | output | 1 | EEPROM bulk-erase request |
| ee_erase_ack | input | 1 | Bulk erase done |
| ee_rd_req | output | 1 | EEPROM read-back request |
| ee_rd_addr | output | EE_AW | Read-back address |
| ee_rd_ack | input | 1 | Read data valid |
| ee_rd_data | input | 8 | Read-back data |
| ram_we | output | 1 | RAM write request |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_ack | input | 1 | RAM write accepted |
| cfg_erase | output | 1 | Configuration-erase request |
| cfg_erase_ack | input | 1 | Configuration erase done |
| force_single_chip | output | 1 | Forces single-chip operation |
| boot_done | output | 1 | One-cycle pulse: boot may proceed |
| retry_cnt | output | RETRY_W | Count of verify failures |

## Verification
The bench plants a stuck non-blank byte at the last EEPROM address for a set number of erase passes. A sequencer that stops one address short, or that resumes mid-stream instead of restarting at the serial step, then shows the wrong read count, serial count or retry count.

Each gating input is cleared in turn: the disable bit, the option bit and the mode pins. A design that combined them wrongly would wipe an unlocked part, or would fail to force single-chip mode on a locked part booted normally.

Further vectors target other faults:

- With the EEPROM disabled, an erase that was not skipped shows up.
- A serial acknowledge that arrives only every other cycle catches a request dropped early.
- A reset in the middle of the RAM fill catches state that survives reset.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEND,
        ST_UNPROT,
        ST_ERASE,
        ST_VERIFY,
        ST_FILL,
        ST_CFGCLR,
        ST_DONE,
        ST_HALT
    } wipe_state_e;

    localparam logic [7:0] BLANK     = 8'hFF;
    localparam logic [1:0] MODE_BOOT = 2'b00;

endpackage

// File: rtl/wipe_entry_gate.sv
module wipe_entry_gate #(
    parameter int NOSEC_BIT = 3,
    parameter int EEN_BIT   = 0
) (
    input  logic       sec_fitted,
    input  logic [1:0] mode_pins,
    input  logic [7:0] cfg_word,
    output logic       secured,
    output logic       run_wipe,
    output logic       ee_wipe
);
    import wipe_pkg::*;

    always_comb begin
        secured  = sec_fitted && !cfg_word[NOSEC_BIT];
        run_wipe = secured && (mode_pins == MODE_BOOT);
        ee_wipe  = cfg_word[EEN_BIT];
    end

endmodule

// File: rtl/wipe_addr_ctr.sv
module wipe_addr_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] last_val,
    output logic [W-1:0] cnt,
    output logic         at_last
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == last_val);

    // R6 and R7: the pointer never steps past the final location
    p_step_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        (step && !clr) |-> !at_last)
        else $error("address counter stepped past its limit");

endmodule

// File: rtl/secure_wipe_seq.sv
module secure_wipe_seq #(
    parameter int EE_DEPTH  = 640,
    parameter int RAM_DEPTH = 1024,
    parameter int RETRY_W   = 4,
    parameter int NOSEC_BIT = 3,
    parameter int EEN_BIT   = 0,
    localparam int EE_AW    = (EE_DEPTH  > 1) ? $clog2(EE_DEPTH)  : 1,
    localparam int RAM_AW   = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_fitted,
    input  logic [1:0]         mode_pins,
    input  logic [7:0]         cfg_word,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               tx_ready,
    output logic               prot_clr,
    input  logic               prot_ack,
    output logic               ee_erase,
    input  logic               ee_erase_ack,
    output logic               ee_rd_req,
    output logic [EE_AW-1:0]   ee_rd_addr,
    input  logic               ee_rd_ack,
    input  logic [7:0]         ee_rd_data,
    output logic               ram_we,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [7:0]         ram_wdata,
    input  logic               ram_ack,
    output logic               cfg_erase,
    input  logic               cfg_erase_ack,
    output logic               force_single_chip,
    output logic               boot_done,
    output logic [RETRY_W-1:0] retry_cnt
);
    import wipe_pkg::*;

    localparam int MAX_DEPTH = (EE_DEPTH > RAM_DEPTH) ? EE_DEPTH : RAM_DEPTH;
    localparam int CNT_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
    localparam logic [CNT_W-1:0] EE_LAST  = CNT_W'(EE_DEPTH - 1);
    localparam logic [CNT_W-1:0] RAM_LAST = CNT_W'(RAM_DEPTH - 1);

    wipe_state_e        state, nxt;
    logic               secured, run_wipe, ee_wipe;
    logic               secured_q, unprot_q;
    logic [CNT_W-1:0]   cnt, last_val;
    logic               at_last, ctr_clr, ctr_step;
    logic               verify_fail, verify_pass;

    wipe_entry_gate #(
        .NOSEC_BIT (NOSEC_BIT),
        .EEN_BIT   (EEN_BIT)
    ) u_gate (
        .sec_fitted (sec_fitted),
        .mode_pins  (mode_pins),
        .cfg_word   (cfg_word),
        .secured    (secured),
        .run_wipe   (run_wipe),
        .ee_wipe    (ee_wipe)
    );

    assign verify_fail = (state == ST_VERIFY) && ee_rd_ack && (ee_rd_data != BLANK);
    assign verify_pass = (state == ST_VERIFY) && ee_rd_ack && (ee_rd_data == BLANK);
    assign last_val    = (state == ST_FILL) ? RAM_LAST : EE_LAST;
    assign ctr_clr     = ((state != ST_VERIFY) && (state != ST_FILL))
                       || verify_fail || (verify_pass && at_last);
    assign ctr_step    = (verify_pass && !at_last)
                       || ((state == ST_FILL) && ram_ack && !at_last);

    wipe_addr_ctr #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctr_clr),
        .step     (ctr_step),
        .last_val (last_val),
        .cnt      (cnt),
        .at_last  (at_last)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = run_wipe ? ST_SEND : ST_DONE;
            ST_SEND:   if (tx_ready) nxt = ST_UNPROT;
            ST_UNPROT: if (prot_ack) nxt = ee_wipe ? ST_ERASE : ST_FILL;
            ST_ERASE:  if (ee_erase_ack) nxt = ST_VERIFY;
            ST_VERIFY: begin
                if (verify_fail)                 nxt = ST_SEND;
                else if (verify_pass && at_last) nxt = ST_FILL;
            end
            ST_FILL:   if (ram_ack && at_last) nxt = ST_CFGCLR;
            ST_CFGCLR: if (cfg_erase_ack) nxt = ST_DONE;
            ST_DONE:   nxt = ST_HALT;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and the few flags that track a pass
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            secured_q <= 1'b0;
            unprot_q  <= 1'b0;
            retry_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) secured_q <= secured;
            if (state == ST_SEND) unprot_q <= 1'b0;
            else if ((state == ST_UNPROT) && prot_ack) unprot_q <= 1'b1;
            if (verify_fail && (retry_cnt != {RETRY_W{1'b1}}))
                retry_cnt <= retry_cnt + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        tx_valid   = 1'b0;
        tx_data    = 8'h00;
        prot_clr   = 1'b0;
        ee_erase   = 1'b0;
        ee_rd_req  = 1'b0;
        ram_we     = 1'b0;
        ram_wdata  = 8'h00;
        cfg_erase  = 1'b0;
        boot_done  = 1'b0;
        ee_rd_addr = cnt[EE_AW-1:0];
        ram_addr   = cnt[RAM_AW-1:0];
        unique case (state)
            ST_SEND:   begin tx_valid = 1'b1; tx_data = BLANK; end
            ST_UNPROT: prot_clr  = 1'b1;
            ST_ERASE:  ee_erase  = 1'b1;
            ST_VERIFY: ee_rd_req = 1'b1;
            ST_FILL:   begin ram_we = 1'b1; ram_wdata = BLANK; end
            ST_CFGCLR: cfg_erase = 1'b1;
            ST_DONE:   boot_done = 1'b1;
            default:   ;
        endcase
    end

    assign force_single_chip = secured_q;

    p_wipe_only_locked_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_valid || prot_clr || ee_erase || ram_we || cfg_erase) |-> force_single_chip)
        else $error("wipe request on an unlocked device");

    p_force_held_r2: assert property (@(posedge clk) disable iff (rst)
        force_single_chip |=> force_single_chip)
        else $error("single-chip force dropped");

    p_tx_held_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && tx_data == 8'hFF))
        else $error("serial request dropped before ready");

    p_unprot_first_r4: assert property (@(posedge clk) disable iff (rst)
        ee_erase |-> unprot_q)
        else $error("erase before protect clear");

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (ee_rd_req && ee_rd_ack && ee_rd_data != 8'hFF) |=> tx_valid)
        else $error("verify miss did not restart");

    p_fill_held_r7: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !ram_ack) |=> (ram_we && $stable(ram_addr)))
        else $error("RAM write not held");

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> !boot_done)
        else $error("done longer than one cycle");

endmodule

// File: tb/secure_wipe_seq_bench.sv
module secure_wipe_seq_bench;

    localparam int EE_DEPTH  = 640;
    localparam int RAM_DEPTH = 1024;
    localparam int EE_AW     = 10;
    localparam int RAM_AW    = 10;
    localparam int RETRY_W   = 4;

    // {sec, mode[1:0], cfg[7:0], stuck[1:0], exp_wipe, exp_ee, exp_force}
    localparam int NV = 6;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {1'b1, 2'b00, 8'h01, 2'd0, 1'b1, 1'b1, 1'b1},
        {1'b1, 2'b00, 8'h09, 2'd0, 1'b0, 1'b0, 1'b0},
        {1'b0, 2'b00, 8'h01, 2'd0, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'b01, 8'h01, 2'd0, 1'b0, 1'b0, 1'b1},
        {1'b1, 2'b00, 8'h00, 2'd1, 1'b1, 1'b0, 1'b1},
        {1'b1, 2'b00, 8'h01, 2'd2, 1'b1, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst = 1'b1;
    logic               sec_fitted = 1'b0;
    logic [1:0]         mode_pins = 2'b00;
    logic [7:0]         cfg_word = 8'h00;
    logic               tx_valid, prot_clr, ee_erase, ee_rd_req, ram_we, cfg_erase;
    logic [7:0]         tx_data, ram_wdata;
    logic [EE_AW-1:0]   ee_rd_addr;
    logic [RAM_AW-1:0]  ram_addr;
    logic               force_single_chip, boot_done;
    logic [RETRY_W-1:0] retry_cnt;
    logic tx_ready = 1'b0, prot_ack = 1'b0, ee_erase_ack = 1'b0;
    logic ee_rd_ack = 1'b0, ram_ack = 1'b0, cfg_erase_ack = 1'b0;
    logic [7:0] ee_rd_data = 8'h00;

    secure_wipe_seq u_secure_wipe_seq (
        .clk (clk), .rst (rst), .sec_fitted (sec_fitted), .mode_pins (mode_pins),
        .cfg_word (cfg_word), .tx_valid (tx_valid), .tx_data (tx_data),
        .tx_ready (tx_ready), .prot_clr (prot_clr), .prot_ack (prot_ack),
        .ee_erase (ee_erase), .ee_erase_ack (ee_erase_ack), .ee_rd_req (ee_rd_req),
        .ee_rd_addr (ee_rd_addr), .ee_rd_ack (ee_rd_ack), .ee_rd_data (ee_rd_data),
        .ram_we (ram_we), .ram_addr (ram_addr), .ram_wdata (ram_wdata),
        .ram_ack (ram_ack), .cfg_erase (cfg_erase), .cfg_erase_ack (cfg_erase_ack),
        .force_single_chip (force_single_chip), .boot_done (boot_done),
        .retry_cnt (retry_cnt)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // handshake models: acks answer at the falling edge; serial ready every other cycle
    logic [7:0] ee_mem [EE_DEPTH];
    always @(negedge clk) begin
        tx_ready      <= tx_valid && !tx_ready;
        prot_ack      <= prot_clr;
        ee_erase_ack  <= ee_erase;
        ee_rd_ack     <= ee_rd_req;
        ee_rd_data    <= ee_mem[ee_rd_addr];
        ram_ack       <= ram_we;
        cfg_erase_ack <= cfg_erase;
    end

    // monitors
    logic clr_mon = 1'b0;
    logic [1:0] stuck_cfg = 2'd0;
    int stuck_left, n_tx, n_prot, n_erase, n_rd, n_ram, n_cfg, n_done;
    int ram_next, ee_next;
    bit ram_err, rd_err, order_err, tx_err, prot_pass;

    always @(posedge clk) begin
        if (clr_mon) begin
            for (int i = 0; i < EE_DEPTH; i++) ee_mem[i] <= 8'h5A;
            stuck_left <= int'(stuck_cfg);
            n_tx <= 0; n_prot <= 0; n_erase <= 0; n_rd <= 0;
            n_ram <= 0; n_cfg <= 0; n_done <= 0;
            ram_next <= 0; ee_next <= 0;
            ram_err <= 0; rd_err <= 0; order_err <= 0; tx_err <= 0; prot_pass <= 0;
        end else begin
            if (tx_valid && tx_ready) begin
                n_tx <= n_tx + 1;
                prot_pass <= 0;
                ee_next <= 0;
                if (tx_data != 8'hFF) tx_err <= 1;
            end
            if (prot_clr && prot_ack) begin
                n_prot <= n_prot + 1;
                prot_pass <= 1;
            end
            if (ee_erase && !prot_pass) order_err <= 1;
            if (ee_erase && ee_erase_ack) begin
                n_erase <= n_erase + 1;
                for (int i = 0; i < EE_DEPTH; i++) ee_mem[i] <= 8'hFF;
                if (stuck_left > 0) begin
                    ee_mem[EE_DEPTH-1] <= 8'h00;
                    stuck_left <= stuck_left - 1;
                end
            end
            if (ee_rd_req && ee_rd_ack) begin
                n_rd <= n_rd + 1;
                if (int'(ee_rd_addr) != ee_next) rd_err <= 1;
                ee_next <= ee_next + 1;
            end
            if (ram_we && ram_ack) begin
                n_ram <= n_ram + 1;
                if (int'(ram_addr) != ram_next || ram_wdata != 8'hFF) ram_err <= 1;
                ram_next <= ram_next + 1;
            end
            if (cfg_erase && cfg_erase_ack) n_cfg <= n_cfg + 1;
            if (boot_done) n_done <= n_done + 1;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic apply_reset(input logic s, input logic [1:0] m, input logic [7:0] c,
                               input logic [1:0] st);
        @(negedge clk);
        rst = 1'b1; clr_mon = 1'b1;
        sec_fitted = s; mode_pins = m; cfg_word = c; stuck_cfg = st;
        repeat (3) @(negedge clk);
        clr_mon = 1'b0;
        rst = 1'b0;
    endtask

    initial begin
        // R9: outputs while held in reset
        apply_reset(1'b1, 2'b00, 8'h01, 2'd0);
        rst = 1'b1;
        @(negedge clk);
        chk(!(tx_valid || prot_clr || ee_erase || ee_rd_req || ram_we || cfg_erase),
            "R9", "requests in reset", int'(tx_valid), 0);
        chk(!boot_done && !force_single_chip && retry_cnt == 0,
            "R9", "done/force/retry in reset", int'(retry_cnt), 0);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [15:0] e;
            int wait_c, exp_retry, exp_tx, exp_rd;
            e = VEC[v];
            apply_reset(e[15], e[14:13], e[12:5], e[4:3]);
            wait_c = 0;
            while (!boot_done && wait_c < 20000) begin
                @(negedge clk);
                wait_c++;
            end
            repeat (4) @(negedge clk);
            exp_retry = e[1] ? int'(e[4:3]) : 0;
            exp_tx    = e[2] ? exp_retry + 1 : 0;
            exp_rd    = e[1] ? (exp_retry + 1) * EE_DEPTH : 0;
            chk(n_done == 1, "R8", $sformatf("v%0d done pulses", v), n_done, 1);
            chk(boot_done == 0, "R8", $sformatf("v%0d done stays low", v), int'(boot_done), 0);
            chk(int'(force_single_chip) == int'(e[0]), "R2",
                $sformatf("v%0d force", v), int'(force_single_chip), int'(e[0]));
            chk(n_tx == exp_tx && !tx_err, "R3", $sformatf("v%0d serial bytes", v), n_tx, exp_tx);
            chk(n_erase == (e[1] ? exp_retry + 1 : 0), "R5",
                $sformatf("v%0d erases", v), n_erase, e[1] ? exp_retry + 1 : 0);
            chk(n_rd == exp_rd && !rd_err, "R6", $sformatf("v%0d reads", v), n_rd, exp_rd);
            chk(int'(retry_cnt) == exp_retry, "R6", $sformatf("v%0d retries", v),
                int'(retry_cnt), exp_retry);
            chk(n_ram == (e[2] ? RAM_DEPTH : 0) && !ram_err, "R7",
                $sformatf("v%0d RAM writes", v), n_ram, e[2] ? RAM_DEPTH : 0);
            chk(n_cfg == int'(e[2]), "R8", $sformatf("v%0d cfg erase", v), n_cfg, int'(e[2]));
            chk(!order_err && n_prot == exp_tx, "R4", $sformatf("v%0d protect clears", v),
                n_prot, exp_tx);
            if (!e[2])
                chk(wait_c == 1, "R1", $sformatf("v%0d fast done cycles", v), wait_c, 1);
        end

        // R9: reset in the middle of the RAM fill
        apply_reset(1'b1, 2'b00, 8'h01, 2'd1);
        while (!(ram_we && ram_addr == 10'd100)) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!(tx_valid || ram_we || ee_rd_req || cfg_erase) && !boot_done,
            "R9", "requests after mid-fill reset", int'(ram_we), 0);
        chk(retry_cnt == 0 && !force_single_chip, "R9", "retry after mid-fill reset",
            int'(retry_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_valid && tx_data == 8'hFF, "R3", "serial step restarts after reset",
            int'(tx_valid), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule